// File: doc/BRIEF.md
# Debounced Key Readback with Interrupt

This block watches a row of key-sense inputs and keeps a filtered copy of them in a key register. A key that is shorted reads as 0 and an open key reads as 1. The raw levels are taken only when the display scanner pulses a sample strobe, which happens once per scan cycle. A new pattern is written to the register only after it has stayed unchanged across a set number of ticks of a millisecond time base. The default is 20 ticks.

When the filtered value changes, the block drives an open-drain interrupt line low. Host logic releases the line by starting a read of the key register. For the first pattern loaded after reset, the register is filled without raising an interrupt.

When self-addressing is enabled, two key positions act as hard-wired address straps. These are the F and G segment positions: bit 1 and bit 0. Their latest sampled levels go straight to a 2-bit address output with no filtering. Inside the key register these two positions read as 1. They neither delay nor trigger an update of the register.

Top module: `key_readback`

## Requirements
- R1: Key register bit i holds the filtered level of key input i, with 1 meaning open and 0 meaning shorted. Every key reads 1 after reset.
- R2: Key inputs are taken only in a cycle where `sample_stb` is high. Changes on `key_raw` at other times have no effect.
- R3: A sampled pattern is written to the key register two cycles after the `DEBOUNCE_MS`-th `ms_tick` that follows the last change of the pattern. It is written no earlier than that.
- R4: Any sample whose counted bits differ from the previous sample restarts the stable-time count. Patterns that bounce faster than the window never reach the register.
- R5: When the key register takes a value different from its old one, `irq_pull` goes to 1 (line held low) in the same cycle as the register update.
- R6: A pulse on `rd_start` returns `irq_pull` to 0 on the next edge and leaves the key register unchanged. A new change arriving in the same cycle keeps the line asserted.
- R7: The first stable pattern after reset is loaded into the key register without asserting `irq_pull`.
- R8: While `self_addr_en` is 1, `strap_addr` equals {key_raw[1], key_raw[0]} from the latest sample, one cycle after the strobe and without filtering. While `self_addr_en` is 0, `strap_addr` reads 00.
- R9: While `self_addr_en` is 1, key register bits 1 and 0 read 1. Changes on those two inputs neither restart the stable count nor raise `irq_pull`.
- R10: A pattern that settles to the value already held does not assert `irq_pull`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_stb | input | 1 | One-cycle pulse per scan cycle; `key_raw` is valid |
| key_raw | input | NKEYS | Raw key levels (1 open, 0 shorted) |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| rd_start | input | 1 | Pulse when a read of the key register begins |
| self_addr_en | input | 1 | Use key bits 1:0 as address straps |
| key_reg | output | NKEYS | Filtered key register |
| strap_addr | output | 2 | Strapped address bits {bit1, bit0} |
| irq_pull | output | 1 | 1 = pull the open-drain interrupt line low, 0 = high impedance |

## Verification
The bench builds the block with `DEBOUNCE_MS` set to 3 and keeps the default eight keys. With the short window, the edge of the filter is checked exactly: one tick short of the window leaves the register unchanged, and the full count commits the pattern. A bounce that restarts the count twice still fits in a few dozen cycles. Because the key count is the default, the strap bits sit at positions 1 and 0 beside six ordinary keys. The mixed case where strap inputs toggle during a count of the other keys is therefore reached as well.

// File: rtl/key_readback.sv
module key_readback #(
  parameter int NKEYS       = 8,
  parameter int DEBOUNCE_MS = 20,
  parameter int STRAP_LO    = 0,
  parameter int STRAP_HI    = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_stb,
  input  logic [NKEYS-1:0] key_raw,
  input  logic             ms_tick,
  input  logic             rd_start,
  input  logic             self_addr_en,
  output logic [NKEYS-1:0] key_reg,
  output logic [1:0]       strap_addr,
  output logic             irq_pull
);
  localparam int CW = $clog2(DEBOUNCE_MS + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(DEBOUNCE_MS);
  localparam logic [NKEYS-1:0] STRAP_MASK =
    (NKEYS'(1) << STRAP_LO) | (NKEYS'(1) << STRAP_HI);

  logic [NKEYS-1:0] smp_q, key_q;
  logic [CW-1:0]    cnt;
  logic             have_smp, loaded, irq_q;
  logic [1:0]       strap_q;

  wire [NKEYS-1:0] mask    = self_addr_en ? STRAP_MASK : '0;
  wire             moved   = have_smp && |((key_raw ^ smp_q) & ~mask);
  wire             settled = have_smp && (cnt == CNT_MAX);
  wire             differs = |((smp_q ^ key_q) & ~mask);
  wire             commit  = settled && (differs || !loaded);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q    <= '1;
      have_smp <= 1'b0;
      strap_q  <= 2'b00;
    end else if (sample_stb) begin
      smp_q    <= key_raw;
      have_smp <= 1'b1;
      strap_q  <= {key_raw[STRAP_HI], key_raw[STRAP_LO]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (sample_stb && (!have_smp || moved))
      cnt <= '0;
    else if (ms_tick && have_smp && cnt != CNT_MAX)
      cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q  <= '1;
      loaded <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (commit) begin
        key_q  <= smp_q;
        loaded <= 1'b1;
      end
      if (commit && loaded && differs)
        irq_q <= 1'b1;
      else if (rd_start)
        irq_q <= 1'b0;
    end
  end

  assign key_reg    = key_q | mask;
  assign strap_addr = self_addr_en ? strap_q : 2'b00;
  assign irq_pull   = irq_q;
endmodule

// File: rtl/key_readback_chk.sv
module key_readback_chk #(
  parameter int NKEYS       = 8,
  parameter int DEBOUNCE_MS = 20,
  parameter int STRAP_LO    = 0,
  parameter int STRAP_HI    = 1,
  localparam int CW = $clog2(DEBOUNCE_MS + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sample_stb,
  input logic [NKEYS-1:0] key_raw,
  input logic             rd_start,
  input logic             self_addr_en,
  input logic [1:0]       strap_addr,
  input logic             irq_pull,
  input logic [NKEYS-1:0] key_q,
  input logic [CW-1:0]    cnt,
  input logic             loaded
);
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEBOUNCE_MS));

  p_update_after_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(key_q) |-> $past(cnt) == CW'(DEBOUNCE_MS));

  p_irq_on_change_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_pull) |-> key_q != $past(key_q));

  p_irq_release_on_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_pull) |-> $past(rd_start));

  p_first_load_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(loaded) |-> !$rose(irq_pull));

  p_strap_direct_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (self_addr_en && $past(self_addr_en) && $past(sample_stb)) |->
      strap_addr == {$past(key_raw[STRAP_HI]), $past(key_raw[STRAP_LO])});
endmodule

bind key_readback key_readback_chk #(
  .NKEYS(NKEYS), .DEBOUNCE_MS(DEBOUNCE_MS), .STRAP_LO(STRAP_LO), .STRAP_HI(STRAP_HI)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb), .key_raw(key_raw),
  .rd_start(rd_start), .self_addr_en(self_addr_en), .strap_addr(strap_addr),
  .irq_pull(irq_pull), .key_q(key_q), .cnt(cnt), .loaded(loaded)
);

// File: tb/test_key_readback.sv
`timescale 1ns/1ps
module test_key_readback;
  localparam int NK = 8;
  localparam int DB = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sample_stb = 1'b0, ms_tick = 1'b0, rd_start = 1'b0, self_addr_en = 1'b0;
  logic [NK-1:0] key_raw = '1;
  logic [NK-1:0] key_reg;
  logic [1:0] strap_addr;
  logic irq_pull;
  int total = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  key_readback #(.NKEYS(NK), .DEBOUNCE_MS(DB)) i_key_readback (
    .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb), .key_raw(key_raw),
    .ms_tick(ms_tick), .rd_start(rd_start), .self_addr_en(self_addr_en),
    .key_reg(key_reg), .strap_addr(strap_addr), .irq_pull(irq_pull));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic smp(input logic [NK-1:0] v);
    @(negedge clk); key_raw = v; sample_stb = 1'b1;
    @(negedge clk); sample_stb = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk); ms_tick = 1'b1;
    @(negedge clk); ms_tick = 1'b0;
  endtask

  task automatic settle(input logic [NK-1:0] v, input int n);
    for (int i = 0; i < n; i++) begin smp(v); tick(); end
    cyc(2);
  endtask

  task automatic read_key();
    @(negedge clk); rd_start = 1'b1;
    @(negedge clk); rd_start = 1'b0;
    cyc(1);
  endtask

  task automatic t_reset();
    chk("R1 reset key", key_reg, 8'hFF);
    chk("R7 reset irq", irq_pull, 0);
    chk("R8 reset strap", strap_addr, 0);
  endtask

  task automatic t_first_load();
    settle(8'hA5, DB + 1);
    chk("R1 first load value", key_reg, 8'hA5);
    chk("R7 first load no irq", irq_pull, 0);
  endtask

  task automatic t_change();
    settle(8'h5A, DB - 1);
    chk("R3 held before window", key_reg, 8'hA5);
    chk("R3 no irq before window", irq_pull, 0);
    settle(8'h5A, 1);
    chk("R3 update at window", key_reg, 8'h5A);
    chk("R5 irq on change", irq_pull, 1);
  endtask

  task automatic t_read();
    read_key();
    chk("R6 irq released", irq_pull, 0);
    chk("R6 key kept on read", key_reg, 8'h5A);
  endtask

  task automatic t_bounce();
    smp(8'h0F); tick(); tick();
    smp(8'hF0); tick(); tick();
    smp(8'h0F); tick(); tick();
    cyc(2);
    chk("R4 bounce filtered", key_reg, 8'h5A);
    chk("R4 bounce no irq", irq_pull, 0);
    settle(8'h0F, DB);
    chk("R4 settles after bounce", key_reg, 8'h0F);
    read_key();
  endtask

  task automatic t_no_strobe();
    @(negedge clk); key_raw = 8'h00;
    for (int i = 0; i < DB + 2; i++) tick();
    cyc(2);
    chk("R2 no strobe ignored", key_reg, 8'h0F);
    chk("R2 no strobe no irq", irq_pull, 0);
  endtask

  task automatic t_same();
    settle(8'h0F, DB + 2);
    chk("R10 same value no irq", irq_pull, 0);
  endtask

  task automatic t_self_addr();
    settle(8'h3C, DB + 1);
    read_key();
    @(negedge clk); self_addr_en = 1'b1;
    cyc(1);
    chk("R9 strap bits read one", key_reg, 8'h3F);
    smp(8'h3E); cyc(1);
    chk("R8 strap direct", strap_addr, 2'b10);
    for (int i = 0; i < DB + 2; i++) begin
      smp((i % 2 == 0) ? 8'h3D : 8'h3E); tick();
    end
    cyc(2);
    chk("R9 strap toggles no irq", irq_pull, 0);
    chk("R9 strap toggles key", key_reg, 8'h3F);
    smp(8'hC1); tick();
    smp(8'hC2); tick();
    smp(8'hC1); tick();
    cyc(2);
    chk("R9 strap no restart", key_reg, 8'hC3);
    chk("R5 irq self addr", irq_pull, 1);
    chk("R8 strap latest", strap_addr, 2'b01);
    read_key();
    @(negedge clk); self_addr_en = 1'b0;
    cyc(1);
    chk("R8 strap off", strap_addr, 2'b00);
    chk("R1 key bits back", key_reg, 8'hC1);
  endtask

  initial begin
    cyc(4);
    rst_n = 1'b1;
    cyc(2);
    t_reset();
    t_first_load();
    t_change();
    t_read();
    t_bounce();
    t_no_strobe();
    t_same();
    t_self_addr();
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule